// File: doc/BRIEF.md
# Dual-Mode Serial I/O Unit

This block holds one small register that serves either as a serial shift register or as a binary event counter, depending on a mode control bit. In shift mode the register moves one place toward its most significant bit on every instruction-cycle tick, taking the synchronized serial input at bit 0. In counter mode the register counts falling transitions on the same serial input. A parallel exchange port lets the surrounding core read the register contents and write new contents in one cycle.

The meaning of the two output pins changes with the mode. In shift mode the serial-out pin carries the register's top bit when the output-enable bit is set and stays low otherwise, and the serial-clock pin repeats the instruction tick when the clock-latch bit is set. In counter mode both pins just reflect static control bits: serial-out shows the output-enable bit and serial-clock shows the clock-latch bit.

Top module: `sio_dual_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the register (xchg_q) is cleared to 0 and the input synchronizer is cleared to 0.
- R2: With mode_cnt = 0 (shift mode) and no exchange, each clock edge where tick is 1 moves the register one place toward the MSB, with the synchronized serial_in entering bit 0; edges without tick leave it unchanged.
- R3: In shift mode with out_en = 1, serial_out equals register bit WIDTH-1 (the MSB).
- R4: In shift mode with out_en = 0, serial_out is 0 while shifting still updates the register.
- R5: With mode_cnt = 1 (counter mode) and no exchange, the register increments by one for each falling transition of the synchronized serial_in, wrapping from all-ones to 0; rising transitions and tick have no effect.
- R6: In counter mode, serial_out equals out_en.
- R7: In shift mode, serial_clk equals tick when clk_latch = 1 and is 0 when clk_latch = 0.
- R8: In counter mode, serial_clk equals clk_latch.
- R9: A clock edge with xchg_en = 1 loads xchg_data into the register; xchg_q shows the previous contents until that edge. The load takes priority, and any shift or count due on that edge is dropped.
- R10: serial_in passes through SYNC_STAGES flip-flops before use, so with SYNC_STAGES = 2 a falling transition in counter mode is counted on the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle instruction-cycle strobe |
| mode_cnt | input | 1 | 0 = shift mode, 1 = counter mode |
| out_en | input | 1 | Output-enable control bit |
| clk_latch | input | 1 | Serial clock-latch control bit |
| serial_in | input | 1 | Serial data or count input (asynchronous) |
| xchg_en | input | 1 | Exchange strobe: load xchg_data this edge |
| xchg_data | input | WIDTH | Value written by an exchange |
| xchg_q | output | WIDTH | Current register contents (read side of exchange) |
| serial_out | output | 1 | Serial-out pin |
| serial_clk | output | 1 | Serial-clock pin |

## Verification
The bench builds the unit with its defaults, WIDTH = 4 and SYNC_STAGES = 2. A 4-bit register lets the counter reach its all-ones value and wrap with a handful of input edges, and a full shift pattern fills the register in four ticks. Two synchronizer stages fix the count latency at three edges, which lets the bench line up a falling edge exactly with an exchange to check that the load wins and the count is lost.

// File: rtl/sio_pkg.sv
// Shared types for the dual-mode serial I/O unit.
package sio_pkg;
    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_COUNT = 1'b1
    } sio_mode_e;
endpackage

// File: rtl/sio_in_sync.sv
// Input synchronizer with falling-transition detector.
// Assumes: STAGES >= 2; din is asynchronous to clk.
module sio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= din;
    end

    // Remaining stages, one flop per stage.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= 1'b0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    // Previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= pipe[STAGES-1];
    end

    assign dout = pipe[STAGES-1];
    assign fall = prev & ~pipe[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall) else $error("fall pulse longer than one cycle"); // R5
endmodule

// File: rtl/sio_data_reg.sv
// Shared shift/count register with exchange load.
// Assumes: WIDTH >= 2; si and fall are already synchronous to clk.
module sio_data_reg
    import sio_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sio_mode_e        mode,
    input  logic             tick,
    input  logic             si,
    input  logic             fall,
    input  logic             ld_en,
    input  logic [WIDTH-1:0] ld_data,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

    // Register update: load beats shift or count.
    always_ff @(posedge clk) begin
        if (!rst_n)                             q <= '0;
        else if (ld_en)                         q <= ld_data;
        else if (mode == MODE_SHIFT && tick)    q <= {q[WIDTH-2:0], si};
        else if (mode == MODE_COUNT && fall)    q <= q + ONE;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> q == $past(ld_data)) else $error("load lost"); // R9
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && mode == MODE_SHIFT && tick) |=> (q[0] == $past(si)) && (q[WIDTH-1:1] == $past(q[WIDTH-2:0])))
        else $error("bad shift step"); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && mode == MODE_COUNT && fall && q == FULL) |=> q == '0)
        else $error("counter did not wrap"); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !(mode == MODE_SHIFT && tick) && !(mode == MODE_COUNT && fall)) |=> $stable(q))
        else $error("register changed while idle"); // R2
endmodule

// File: rtl/sio_pin_mux.sv
// Mode-dependent drive of the serial-out and serial-clock pins.
// Assumes: all inputs synchronous; outputs are purely combinational.
module sio_pin_mux
    import sio_pkg::*;
(
    input  sio_mode_e mode,
    input  logic      out_en,
    input  logic      clk_latch,
    input  logic      tick,
    input  logic      msb,
    output logic      so,
    output logic      sk
);
    // Select pin sources according to mode.
    always_comb begin
        if (mode == MODE_COUNT) begin
            so = out_en;
            sk = clk_latch;
        end else begin
            so = out_en & msb;
            sk = clk_latch & tick;
        end
    end
endmodule

// File: rtl/sio_dual_unit.sv
// Top of the dual-mode serial I/O unit: synchronizer, shared
// register and pin mux. Assumes tick is a one-cycle strobe and
// control bits are synchronous to clk.
module sio_dual_unit
    import sio_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mode_cnt,
    input  logic             out_en,
    input  logic             clk_latch,
    input  logic             serial_in,
    input  logic             xchg_en,
    input  logic [WIDTH-1:0] xchg_data,
    output logic [WIDTH-1:0] xchg_q,
    output logic             serial_out,
    output logic             serial_clk
);
    sio_mode_e mode;
    logic      si_s;
    logic      si_fall;

    assign mode = sio_mode_e'(mode_cnt);

    sio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (serial_in),
        .dout (si_s),
        .fall (si_fall)
    );

    sio_data_reg #(.WIDTH(WIDTH)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .tick   (tick),
        .si     (si_s),
        .fall   (si_fall),
        .ld_en  (xchg_en),
        .ld_data(xchg_data),
        .q      (xchg_q)
    );

    sio_pin_mux u_mux (
        .mode     (mode),
        .out_en   (out_en),
        .clk_latch(clk_latch),
        .tick     (tick),
        .msb      (xchg_q[WIDTH-1]),
        .so       (serial_out),
        .sk       (serial_clk)
    );

    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cnt && !out_en) |-> !serial_out) else $error("serial_out not quiet"); // R4
    AST_SK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cnt && !clk_latch) |-> !serial_clk) else $error("serial_clk not held low"); // R7
    AST_SK_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cnt |-> serial_clk == clk_latch) else $error("serial_clk not latch"); // R8
    AST_SO_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cnt |-> serial_out == out_en) else $error("serial_out not enable bit"); // R6
endmodule

// File: tb/sim_sio_dual_unit.sv
// Directed bench for the dual-mode serial I/O unit.
module sim_sio_dual_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         mode_cnt = 1'b0;
    logic         out_en = 1'b0;
    logic         clk_latch = 1'b0;
    logic         serial_in = 1'b0;
    logic         xchg_en = 1'b0;
    logic [W-1:0] xchg_data = '0;
    logic [W-1:0] xchg_q;
    logic         serial_out;
    logic         serial_clk;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sio_dual_unit #(.WIDTH(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_cnt(mode_cnt),
        .out_en(out_en), .clk_latch(clk_latch), .serial_in(serial_in),
        .xchg_en(xchg_en), .xchg_data(xchg_data), .xchg_q(xchg_q),
        .serial_out(serial_out), .serial_clk(serial_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Shift one bit in: settle the synchronizer, then one tick.
    task automatic shift_bit(input logic b);
        serial_in = b;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // One full high-then-low cycle on serial_in.
    task automatic pulse_fall();
        serial_in = 1'b1;
        repeat (4) @(negedge clk);
        serial_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] v);
        xchg_data = v;
        xchg_en = 1'b1;
        @(negedge clk);
        xchg_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset contents", xchg_q, 0);
        chk("R1 reset serial_out", serial_out, 0);
    endtask

    task automatic t_shift_visible();
        mode_cnt = 1'b0; out_en = 1'b1; clk_latch = 1'b0;
        shift_bit(1'b1); chk("R2 shift step1", xchg_q, 1);
        shift_bit(1'b0); chk("R2 shift step2", xchg_q, 2);
        shift_bit(1'b1); chk("R2 shift step3", xchg_q, 5);
        chk("R3 msb low", serial_out, 0);
        shift_bit(1'b1); chk("R2 shift step4", xchg_q, 11);
        chk("R3 msb high", serial_out, 1);
        repeat (5) @(negedge clk);
        chk("R2 hold without tick", xchg_q, 11);
    endtask

    task automatic t_shift_quiet();
        out_en = 1'b0;
        shift_bit(1'b0); chk("R4 shifting continues a", xchg_q, 6);
        shift_bit(1'b1); chk("R4 shifting continues b", xchg_q, 13);
        chk("R4 serial_out forced low", serial_out, 0);
    endtask

    task automatic t_sclk_shift();
        mode_cnt = 1'b0; clk_latch = 1'b1; tick = 1'b1;
        #1 chk("R7 sclk follows tick high", serial_clk, 1);
        @(negedge clk); tick = 1'b0;
        #1 chk("R7 sclk follows tick low", serial_clk, 0);
        clk_latch = 1'b0; tick = 1'b1;
        #1 chk("R7 sclk held low", serial_clk, 0);
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_count();
        mode_cnt = 1'b1; out_en = 1'b0; clk_latch = 1'b0; serial_in = 1'b0;
        repeat (4) @(negedge clk);
        load(4'd13);
        chk("R9 load value", xchg_q, 13);
        pulse_fall(); chk("R5 count 14", xchg_q, 14);
        pulse_fall(); chk("R5 count 15", xchg_q, 15);
        pulse_fall(); chk("R5 wrap to 0", xchg_q, 0);
        pulse_fall(); chk("R5 count 1", xchg_q, 1);
        repeat (3) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
        end
        chk("R5 tick ignored in counter mode", xchg_q, 1);
        serial_in = 1'b1; repeat (5) @(negedge clk);
        chk("R5 rising edge ignored", xchg_q, 1);
        serial_in = 1'b0; @(negedge clk); @(negedge clk);
        chk("R10 not yet counted after two edges", xchg_q, 1);
        @(negedge clk);
        chk("R10 counted on third edge", xchg_q, 2);
    endtask

    task automatic t_count_pins();
        mode_cnt = 1'b1; out_en = 1'b1; clk_latch = 1'b0; #1;
        chk("R6 serial_out = out_en high", serial_out, 1);
        chk("R8 serial_clk = latch low", serial_clk, 0);
        out_en = 1'b0; clk_latch = 1'b1; #1;
        chk("R6 serial_out = out_en low", serial_out, 0);
        chk("R8 serial_clk = latch high", serial_clk, 1);
        clk_latch = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_prio_shift();
        mode_cnt = 1'b0; serial_in = 1'b1;
        repeat (3) @(negedge clk);
        load(4'd5);
        chk("R9 exchange read side", xchg_q, 5);
        tick = 1'b1; xchg_en = 1'b1; xchg_data = 4'd9;
        #1 chk("R9 old contents visible before edge", xchg_q, 5);
        @(negedge clk);
        tick = 1'b0; xchg_en = 1'b0;
        chk("R9 load beats shift", xchg_q, 9);
    endtask

    task automatic t_prio_count();
        mode_cnt = 1'b1; serial_in = 1'b1;
        repeat (4) @(negedge clk);
        load(4'd3);
        serial_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        xchg_en = 1'b1; xchg_data = 4'd6;
        @(negedge clk);
        xchg_en = 1'b0;
        chk("R9 load beats count", xchg_q, 6);
        repeat (4) @(negedge clk);
        chk("R9 dropped count stays dropped", xchg_q, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shift_visible();
        t_shift_quiet();
        t_sclk_shift();
        t_count();
        t_count_pins();
        t_prio_shift();
        t_prio_count();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule